// File: doc/BRIEF.md
# Single-Cycle 8-Bit Register Processor Core

This block is a small processor core that finishes every instruction in one clock. Its datapath is 8 bits wide and its instructions are 16 bits. Each instruction names one register and carries one 8-bit field, which is either an immediate or an address. The core has sixteen 8-bit registers, an 8-bit program counter, an arithmetic unit and two adders. One adder forms the sequential address, PC+2. The other forms the branch target, PC+2 plus the 8-bit field. A combinational decoder turns the 4-bit opcode into datapath selects.

Instruction fetch and data access go through two separate ports. The instruction port presents the program counter as a byte address and takes back a 16-bit word in the same cycle. The data port carries an address, write data and a write strobe, and it returns read data combinationally. The memories behind both ports sit outside the core.

Register writeback picks one of three sources: the link value PC+2, the arithmetic result, or the data read value.

Top module: `cpu8_core`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter to 0 and clears every register to 0. After reset, `imem_addr` reads 0.
- R2: Instruction fields: opcode in bits 15..12, register number in bits 11..8, 8-bit field in bits 7..0. Opcodes: 0 addi, 1 subi, 2 load, 3 store, 4 beq, 5 jmp, 6 jal. Every instruction finishes in one clock.
- R3: addi writes register+field back to the same register, modulo 256, and advances the PC by 2.
- R4: subi writes register−field back to the same register, modulo 256, and advances the PC by 2.
- R5: load drives the field on `dmem_addr` with `dmem_we` low, and writes `dmem_rdata` into the register.
- R6: store drives the field on `dmem_addr`, the register value on `dmem_wdata`, and `dmem_we` high. It writes no register. `dmem_we` is high for no other opcode.
- R7: beq on a register equal to zero loads the PC with PC+2+field, modulo 256.
- R8: beq on a non-zero register loads the PC with PC+2.
- R9: jmp loads the PC with the field and leaves all registers unchanged.
- R10: jal writes PC+2 into the named register and loads the PC with the field.
- R11: Register 0 always reads as 0. Any write to it has no effect.
- R12: Opcodes 7 to 15 only advance the PC by 2. They write no register and no memory.
- R13: All PC arithmetic, sequential and branch, wraps modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 8 | Program counter, used as the instruction byte address |
| imem_data | input | 16 | Instruction word at `imem_addr` |
| dmem_addr | output | 8 | Data memory address |
| dmem_wdata | output | 8 | Register value offered for a store |
| dmem_rdata | input | 8 | Data memory read value |
| dmem_we | output | 1 | Data memory write strobe |

## Verification
The core carries clocked properties that hold on every cycle:
- the PC is zero after reset;
- the data strobe is high only for the store opcode;
- the next PC for jmp, for a taken beq and for a beq that falls through;
- the PC+2 step for undefined opcodes.

Register contents are not visible at the ports, so only directed programs can show the following. Each program ends by storing registers to data memory, where the bench reads them back.
- arithmetic wrap-around;
- load and writeback results;
- the link value written by jal;
- register 0 ignoring writes;
- registers surviving stores, jumps and undefined opcodes.

// File: rtl/cpu8_pkg.sv
`timescale 1ns/100ps
package cpu8_pkg;
    localparam int DW     = 8;
    localparam int NREG   = 16;
    localparam int OPW    = 4;
    localparam int RAW    = $clog2(NREG);
    localparam int IW     = OPW + RAW + DW;
    localparam int PC_INC = 2;

    localparam logic [OPW-1:0] OP_ADDI  = 4'd0;
    localparam logic [OPW-1:0] OP_SUBI  = 4'd1;
    localparam logic [OPW-1:0] OP_LOAD  = 4'd2;
    localparam logic [OPW-1:0] OP_STORE = 4'd3;
    localparam logic [OPW-1:0] OP_BEQ   = 4'd4;
    localparam logic [OPW-1:0] OP_JMP   = 4'd5;
    localparam logic [OPW-1:0] OP_JAL   = 4'd6;

    typedef enum logic [2:0] {
        ALU_NONE  = 3'd0,
        ALU_SUB   = 3'd1,
        ALU_ADD   = 3'd2,
        ALU_PASSX = 3'd3,
        ALU_PASSY = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        WB_LINK = 2'd0,
        WB_ALU  = 2'd1,
        WB_MEM  = 2'd2
    } wb_sel_e;

    typedef struct packed {
        alu_op_e alu_op;
        wb_sel_e wb_sel;
        logic    reg_we;
        logic    mem_we;
        logic    branch;
        logic    jump;
    } ctrl_t;

    typedef struct packed {
        logic [OPW-1:0] op;
        logic [RAW-1:0] rn;
        logic [DW-1:0]  fld;
    } instr_t;

    function automatic logic [DW-1:0] alu_eval(alu_op_e op,
                                               logic [DW-1:0] x,
                                               logic [DW-1:0] y);
        logic [DW-1:0] r;
        case (op)
            ALU_SUB:   r = x - y;
            ALU_ADD:   r = x + y;
            ALU_PASSX: r = x;
            ALU_PASSY: r = y;
            default:   r = '0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/cpu8_decoder.sv
`timescale 1ns/100ps
module cpu8_decoder
    import cpu8_pkg::*;
(
    input  logic [OPW-1:0] op,
    output ctrl_t          ctrl
);
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_NONE;
        ctrl.wb_sel = WB_ALU;
        case (op)
            OP_ADDI: begin
                ctrl.alu_op = ALU_ADD;
                ctrl.reg_we = 1'b1;
            end
            OP_SUBI: begin
                ctrl.alu_op = ALU_SUB;
                ctrl.reg_we = 1'b1;
            end
            OP_LOAD: begin
                ctrl.alu_op = ALU_PASSY;
                ctrl.wb_sel = WB_MEM;
                ctrl.reg_we = 1'b1;
            end
            OP_STORE: begin
                ctrl.alu_op = ALU_PASSY;
                ctrl.mem_we = 1'b1;
            end
            OP_BEQ: begin
                ctrl.alu_op = ALU_PASSX;
                ctrl.branch = 1'b1;
            end
            OP_JMP: begin
                ctrl.jump = 1'b1;
            end
            OP_JAL: begin
                ctrl.jump   = 1'b1;
                ctrl.wb_sel = WB_LINK;
                ctrl.reg_we = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cpu8_alu.sv
`timescale 1ns/100ps
module cpu8_alu
    import cpu8_pkg::*;
#(
    parameter int W = DW
) (
    input  alu_op_e      op,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] res,
    output logic         zero
);
    always_comb begin
        res  = alu_eval(op, x, y);
        zero = (res == '0);
    end
endmodule

// File: rtl/cpu8_regfile.sv
`timescale 1ns/100ps
module cpu8_regfile
    import cpu8_pkg::*;
#(
    parameter int W = DW,
    parameter int N = NREG,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] regs [N];

    assign regs[0] = '0;

    for (genvar g = 1; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && addr == AW'(g))
                regs[g] <= wdata;
        end
    end

    assign rdata = regs[addr];
endmodule

// File: rtl/cpu8_core.sv
`timescale 1ns/100ps
module cpu8_core
    import cpu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    output logic [DW-1:0] imem_addr,
    input  logic [IW-1:0] imem_data,
    output logic [DW-1:0] dmem_addr,
    output logic [DW-1:0] dmem_wdata,
    input  logic [DW-1:0] dmem_rdata,
    output logic          dmem_we
);
    instr_t        ins;
    ctrl_t         ctrl;
    logic [DW-1:0] pc_q, pc_d, pc_plus2, br_target;
    logic [DW-1:0] rd_data, alu_res, wb_data;
    logic          alu_zero;

    assign ins = instr_t'(imem_data);

    cpu8_decoder dec_i (
        .op   (ins.op),
        .ctrl (ctrl)
    );

    cpu8_regfile #(.W(DW), .N(NREG)) rf_i (
        .clk   (clk),
        .rst   (rst),
        .we    (ctrl.reg_we),
        .addr  (ins.rn),
        .wdata (wb_data),
        .rdata (rd_data)
    );

    cpu8_alu #(.W(DW)) alu_i (
        .op   (ctrl.alu_op),
        .x    (rd_data),
        .y    (ins.fld),
        .res  (alu_res),
        .zero (alu_zero)
    );

    always_comb begin
        case (ctrl.wb_sel)
            WB_LINK: wb_data = pc_plus2;
            WB_MEM:  wb_data = dmem_rdata;
            default: wb_data = alu_res;
        endcase
    end

    assign pc_plus2  = pc_q + DW'(PC_INC);
    assign br_target = pc_plus2 + ins.fld;

    always_comb begin
        if (ctrl.jump)
            pc_d = ins.fld;
        else if (ctrl.branch && alu_zero)
            pc_d = br_target;
        else
            pc_d = pc_plus2;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_res;
    assign dmem_wdata = rd_data;
    assign dmem_we    = ctrl.mem_we;

    // R1
    pc_reset_chk: assert property (@(posedge clk) rst |=> pc_q == '0);

    // R6
    store_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> imem_data[15:12] == OP_STORE);

    // R9
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        imem_data[15:12] == OP_JMP |=> pc_q == $past(imem_data[7:0]));

    // R7
    branch_take_chk: assert property (@(posedge clk) disable iff (rst)
        (imem_data[15:12] == OP_BEQ && dmem_wdata == '0)
        |=> pc_q == DW'($past(pc_q) + DW'(PC_INC) + $past(imem_data[7:0])));

    // R8
    branch_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (imem_data[15:12] == OP_BEQ && dmem_wdata != '0)
        |=> pc_q == DW'($past(pc_q) + DW'(PC_INC)));

    // R12
    nop_advance_chk: assert property (@(posedge clk) disable iff (rst)
        imem_data[15:12] > OP_JAL |=> pc_q == DW'($past(pc_q) + DW'(PC_INC)));
endmodule

// File: tb/cpu8_core_tb.sv
`timescale 1ns/100ps
module cpu8_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  imem_addr, dmem_addr, dmem_wdata, dmem_rdata;
    logic [15:0] imem_data;
    logic        dmem_we;

    logic [15:0] imem [256];
    logic [7:0]  dmem [256];

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    cpu8_core dut_i (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata),
        .dmem_we    (dmem_we)
    );

    assign imem_data  = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];

    always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

    function automatic logic [15:0] mk(input logic [3:0] op, input logic [3:0] r,
                                       input logic [7:0] f);
        return {op, r, f};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            imem[i] = 16'hF000;
            dmem[i] = 8'h00;
        end
    endtask

    task automatic boot();
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        clear_mem();
        imem[0] = mk(0, 5, 8'h07);
        boot();
        step(1);
        imem[0] = mk(3, 5, 8'h10);
        dmem[8'h10] = 8'hAA;
        boot();
        chk("R1 pc after reset", {8'h0, imem_addr}, 16'h0000);
        step(1);
        chk("R1 register cleared", {8'h0, dmem[8'h10]}, 16'h0000);
    endtask

    task automatic t_arith();
        clear_mem();
        imem[0]  = mk(0, 1, 8'h30);
        imem[2]  = mk(1, 1, 8'h05);
        imem[4]  = mk(3, 1, 8'h20);
        imem[6]  = mk(0, 2, 8'hF0);
        imem[8]  = mk(0, 2, 8'h20);
        imem[10] = mk(3, 2, 8'h21);
        imem[12] = mk(1, 3, 8'h01);
        imem[14] = mk(3, 3, 8'h22);
        boot();
        step(8);
        chk("R3 R4 add then sub", {8'h0, dmem[8'h20]}, 16'h002B);
        chk("R3 add wraps", {8'h0, dmem[8'h21]}, 16'h0010);
        chk("R4 sub wraps", {8'h0, dmem[8'h22]}, 16'h00FF);
        chk("R2 one clock per instruction", {8'h0, imem_addr}, 16'h0010);
    endtask

    task automatic t_mem();
        clear_mem();
        dmem[8'h40] = 8'h5A;
        imem[0] = mk(2, 4, 8'h40);
        imem[2] = mk(3, 4, 8'h41);
        imem[4] = mk(0, 7, 8'h09);
        imem[6] = mk(3, 7, 8'h44);
        imem[8] = mk(3, 7, 8'h45);
        boot();
        chk("R5 load strobe low", {15'h0, dmem_we}, 16'h0000);
        chk("R5 load address", {8'h0, dmem_addr}, 16'h0040);
        step(1);
        chk("R6 store strobe", {15'h0, dmem_we}, 16'h0001);
        chk("R6 store address", {8'h0, dmem_addr}, 16'h0041);
        chk("R6 store data", {8'h0, dmem_wdata}, 16'h005A);
        step(4);
        chk("R5 loaded value stored", {8'h0, dmem[8'h41]}, 16'h005A);
        chk("R6 store keeps register", {8'h0, dmem[8'h45]}, 16'h0009);
    endtask

    task automatic t_branch();
        clear_mem();
        imem[0]  = mk(4, 1, 8'h06);
        imem[2]  = mk(0, 2, 8'h50);
        imem[8]  = mk(0, 3, 8'h01);
        imem[10] = mk(4, 3, 8'h20);
        imem[12] = mk(3, 2, 8'h30);
        dmem[8'h30] = 8'hEE;
        boot();
        step(1);
        chk("R7 beq taken", {8'h0, imem_addr}, 16'h0008);
        step(2);
        chk("R8 beq not taken", {8'h0, imem_addr}, 16'h000C);
        step(1);
        chk("R7 skipped instruction", {8'h0, dmem[8'h30]}, 16'h0000);
        clear_mem();
        imem[0]     = mk(5, 0, 8'hF0);
        imem[8'hF0] = mk(4, 0, 8'h10);
        boot();
        step(2);
        chk("R13 branch target wraps", {8'h0, imem_addr}, 16'h0002);
        clear_mem();
        imem[0]     = mk(5, 0, 8'hFE);
        imem[8'hFE] = mk(0, 1, 8'h01);
        boot();
        step(2);
        chk("R13 sequential wraps", {8'h0, imem_addr}, 16'h0000);
    endtask

    task automatic t_jump();
        clear_mem();
        imem[0]     = mk(0, 5, 8'h11);
        imem[2]     = mk(5, 5, 8'h30);
        imem[8'h30] = mk(6, 9, 8'h50);
        imem[8'h50] = mk(3, 9, 8'h60);
        imem[8'h52] = mk(3, 5, 8'h61);
        boot();
        step(2);
        chk("R9 jmp target", {8'h0, imem_addr}, 16'h0030);
        step(1);
        chk("R10 jal target", {8'h0, imem_addr}, 16'h0050);
        step(2);
        chk("R10 link value", {8'h0, dmem[8'h60]}, 16'h0032);
        chk("R9 jmp keeps register", {8'h0, dmem[8'h61]}, 16'h0011);
    endtask

    task automatic t_r0();
        clear_mem();
        dmem[8'h71] = 8'hCC;
        dmem[8'h70] = 8'hFF;
        imem[0] = mk(0, 0, 8'h77);
        imem[2] = mk(2, 0, 8'h71);
        imem[4] = mk(6, 0, 8'h08);
        imem[8] = mk(3, 0, 8'h70);
        boot();
        step(4);
        chk("R11 r0 stays zero", {8'h0, dmem[8'h70]}, 16'h0000);
        chk("R11 pc after sequence", {8'h0, imem_addr}, 16'h000A);
    endtask

    task automatic t_nop();
        clear_mem();
        imem[0] = mk(0, 5, 8'h22);
        imem[2] = mk(7, 5, 8'h99);
        imem[4] = mk(9, 5, 8'h99);
        imem[6] = mk(15, 5, 8'h99);
        imem[8] = mk(3, 5, 8'h50);
        boot();
        step(1);
        for (int k = 0; k < 3; k++) begin
            chk("R12 no memory write", {15'h0, dmem_we}, 16'h0000);
            step(1);
        end
        chk("R12 pc advanced", {8'h0, imem_addr}, 16'h0008);
        step(1);
        chk("R12 register untouched", {8'h0, dmem[8'h50]}, 16'h0022);
    endtask

    bit finished = 1'b0;

    initial begin
        t_reset();
        t_arith();
        t_mem();
        t_branch();
        t_jump();
        t_r0();
        t_nop();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule